// File: doc/BRIEF.md
# Shadowed Synthesizer Configuration Bank

This block holds the settings of a clock synthesizer in two layers. A host port, normally driven by a serial slave controller, can only reach a staging layer. A separate live layer drives the synthesizer: a feedback divider value, and the spread-spectrum up flag, down flag and amount. Host writes therefore never change the synthesizer directly. A command register moves data between the two layers. A store command puts the staged settings live. A copy command brings the live settings back into staging so the host can read them.

Every command byte must carry the bitwise inverse of its three action flags. Any host access that the block rejects gets a not-acknowledge response. Two sticky error flags record rejected commands and rejected writes. The host can read these flags and can clear them with a command.

Each host access takes one cycle. The response (valid, ack, read data) is registered and appears on the next cycle. A live-layer update caused by a store shows on the outputs in that same next cycle.

Top module: `cfg_shadow_bank`

## Requirements
- R1: After reset the live divider equals parameter DIV_DEFAULT (32) and spread up, down and amount are 0. Reading addresses 0x01..0x04 returns the same reset values: 0x20, 0x00, 0x00 and 0x00.
- R2: A write to address 0x01, 0x02 or 0x03 is acknowledged and changes only the staging layer; the live outputs keep their value. An idle cycle produces no response.
- R3: Writing 0xD2 to address 0x00 (store) is acknowledged, and on the response cycle all live fields take the staged values together.
- R4: Writing 0xE1 to address 0x00 (copy) is acknowledged and loads staging from the live layer; a later read of 0x01..0x03 returns the live values.
- R5: A command byte is valid only when bit 7 is 1, bit 3 is 0 and bits 6..4 are the inverse of bits 2..0. Any other command byte is answered with NACK, has no action, and sets sticky status bit 0.
- R6: A read of address 0x00 is answered with NACK and read data 0x00.
- R7: A write to 0x04 or to any address above 0x04 is answered with NACK and sets sticky status bit 1. A read above 0x04 is answered with NACK.
- R8: The field layout is as follows. Register 0x01 holds divider bits 7..0. Register 0x02 holds divider bits 10..8 in bits 2..0. Register 0x03 holds up in bit 7, down in bit 6 and the amount in bits 4..0. Undefined bits are ignored on write and read back as 0.
- R9: Writing 0xB4 to address 0x00 (clear) is acknowledged and clears both sticky status bits. Register 0x04 reads status bit 0 (bad command) and status bit 1 (rejected write).
- R10: A valid command with copy and store both set (0xC3) first stores staging to live and then copies, so staging keeps its contents. A valid command with no flag set (0xF0) is acknowledged and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Host access request for this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_addr | input | 8 | Register address |
| acc_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response to the previous cycle's access |
| rsp_ack | output | 1 | 1 = accepted, 0 = rejected |
| rsp_rdata | output | 8 | Read data, 0 when rejected or on a write |
| div_m | output | DIV_W | Live feedback divider |
| ss_up | output | 1 | Live spread up flag |
| ss_dn | output | 1 | Live spread down flag |
| ss_amt | output | AMT_W | Live spread amount |

## Verification
Copy and store can fire in the same cycle when one command byte sets both flags. The bench first stages values that differ from the live layer and then writes 0xC3. It checks that the live outputs take the staged values on the response cycle. It then reads staging back to show that the copy did not undo the staged data. The reference model applies the store before the copy and compares every output on every clock.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;
   localparam logic [7:0] ADDR_CMD    = 8'h00;
   localparam logic [7:0] ADDR_DIV_LO = 8'h01;
   localparam logic [7:0] ADDR_DIV_HI = 8'h02;
   localparam logic [7:0] ADDR_SPREAD = 8'h03;
   localparam logic [7:0] ADDR_STATUS = 8'h04;

   localparam int CMD_COPY  = 0;
   localparam int CMD_STORE = 1;
   localparam int CMD_CLEAR = 2;
   localparam int CMD_ZERO  = 3;
   localparam int CMD_ONE   = 7;

   localparam int SPR_UP = 7;
   localparam int SPR_DN = 6;

   localparam int FLAG_CMD  = 0;
   localparam int FLAG_ADDR = 1;
   localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
   import cfg_shadow_pkg::*;
(
   input  logic       cmd_wr,
   input  logic [7:0] cmd_byte,
   output logic       cmd_ok,
   output logic       copy_fire,
   output logic       store_fire,
   output logic       clear_fire
);
   logic [2:0] flags_lo;
   logic [2:0] flags_hi;

   always_comb begin
      flags_lo   = cmd_byte[2:0];
      flags_hi   = cmd_byte[6:4];
      cmd_ok     = cmd_byte[CMD_ONE] && !cmd_byte[CMD_ZERO] && (flags_hi == ~flags_lo);
      copy_fire  = cmd_wr && cmd_ok && flags_lo[CMD_COPY];
      store_fire = cmd_wr && cmd_ok && flags_lo[CMD_STORE];
      clear_fire = cmd_wr && cmd_ok && flags_lo[CMD_CLEAR];
   end
endmodule

// File: rtl/cfg_main_regs.sv
module cfg_main_regs #(
   parameter int DIV_W       = 11,
   parameter int AMT_W       = 5,
   parameter int DIV_DEFAULT = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DIV_W-1:0] in_div,
   input  logic             in_up,
   input  logic             in_dn,
   input  logic [AMT_W-1:0] in_amt,
   output logic [DIV_W-1:0] q_div,
   output logic             q_up,
   output logic             q_dn,
   output logic [AMT_W-1:0] q_amt
);
   localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(DIV_DEFAULT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_div <= DIV_RST;
         q_up  <= 1'b0;
         q_dn  <= 1'b0;
         q_amt <= '0;
      end else if (load) begin
         q_div <= in_div;
         q_up  <= in_up;
         q_dn  <= in_dn;
         q_amt <= in_amt;
      end
   end
endmodule

// File: rtl/cfg_stage_regs.sv
module cfg_stage_regs
   import cfg_shadow_pkg::*;
#(
   parameter int DIV_W       = 11,
   parameter int AMT_W       = 5,
   parameter int DIV_DEFAULT = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_addr,
   input  logic [7:0]       wr_data,
   input  logic             load,
   input  logic [DIV_W-1:0] src_div,
   input  logic             src_up,
   input  logic             src_dn,
   input  logic [AMT_W-1:0] src_amt,
   output logic [DIV_W-1:0] st_div,
   output logic             st_up,
   output logic             st_dn,
   output logic [AMT_W-1:0] st_amt
);
   localparam int HI_W = DIV_W - 8;
   localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(DIV_DEFAULT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_div <= DIV_RST;
         st_up  <= 1'b0;
         st_dn  <= 1'b0;
         st_amt <= '0;
      end else if (load) begin
         st_div <= src_div;
         st_up  <= src_up;
         st_dn  <= src_dn;
         st_amt <= src_amt;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_DIV_LO: st_div[7:0]       <= wr_data;
            ADDR_DIV_HI: st_div[DIV_W-1:8] <= wr_data[HI_W-1:0];
            ADDR_SPREAD: begin
               st_up  <= wr_data[SPR_UP];
               st_dn  <= wr_data[SPR_DN];
               st_amt <= wr_data[AMT_W-1:0];
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cfg_status_flags.sv
module cfg_status_flags #(
   parameter int NFLAG = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] set,
   input  logic             clear,
   output logic [NFLAG-1:0] flags
);
   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flags[i] <= 1'b0;
         else if (set[i]) flags[i] <= 1'b1;
         else if (clear)  flags[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
   import cfg_shadow_pkg::*;
#(
   parameter int DIV_W       = 11,
   parameter int AMT_W       = 5,
   parameter int DIV_DEFAULT = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic             acc_write,
   input  logic [7:0]       acc_addr,
   input  logic [7:0]       acc_wdata,
   output logic             rsp_valid,
   output logic             rsp_ack,
   output logic [7:0]       rsp_rdata,
   output logic [DIV_W-1:0] div_m,
   output logic             ss_up,
   output logic             ss_dn,
   output logic [AMT_W-1:0] ss_amt
);
   localparam int HI_W  = DIV_W - 8;
   localparam int PAD_W = 8 - HI_W;
   localparam int GAP_W = 6 - AMT_W;

   if (DIV_W < 9 || DIV_W > 15) begin : g_bad_div
      $error("DIV_W must lie in 9..15");
   end
   if (AMT_W < 1 || AMT_W > 5) begin : g_bad_amt
      $error("AMT_W must lie in 1..5");
   end
   if (DIV_DEFAULT < 0 || DIV_DEFAULT >= (1 << DIV_W)) begin : g_bad_def
      $error("DIV_DEFAULT does not fit DIV_W");
   end

   logic wr_req, rd_req, cmd_wr, stage_wr, stage_addr, read_addr;
   logic cmd_ok, copy_fire, store_fire, clear_fire;
   logic [DIV_W-1:0] st_div, src_div;
   logic             st_up, st_dn, src_up, src_dn;
   logic [AMT_W-1:0] st_amt, src_amt;
   logic [NUM_FLAGS-1:0] flag_set, status_q;
   logic       acc_ok;
   logic [7:0] rd_mux;

   always_comb begin
      wr_req     = acc_valid && acc_write;
      rd_req     = acc_valid && !acc_write;
      cmd_wr     = wr_req && (acc_addr == ADDR_CMD);
      stage_addr = (acc_addr >= ADDR_DIV_LO) && (acc_addr <= ADDR_SPREAD);
      read_addr  = (acc_addr >= ADDR_DIV_LO) && (acc_addr <= ADDR_STATUS);
      stage_wr   = wr_req && stage_addr;
   end

   cfg_cmd_decode u_dec (
      .cmd_wr    (cmd_wr),
      .cmd_byte  (acc_wdata),
      .cmd_ok    (cmd_ok),
      .copy_fire (copy_fire),
      .store_fire(store_fire),
      .clear_fire(clear_fire)
   );

   cfg_main_regs #(.DIV_W(DIV_W), .AMT_W(AMT_W), .DIV_DEFAULT(DIV_DEFAULT)) u_main (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (store_fire),
      .in_div(st_div),
      .in_up (st_up),
      .in_dn (st_dn),
      .in_amt(st_amt),
      .q_div (div_m),
      .q_up  (ss_up),
      .q_dn  (ss_dn),
      .q_amt (ss_amt)
   );

   // store is ordered before copy: copy takes the value main is about to hold
   always_comb begin
      src_div = store_fire ? st_div : div_m;
      src_up  = store_fire ? st_up  : ss_up;
      src_dn  = store_fire ? st_dn  : ss_dn;
      src_amt = store_fire ? st_amt : ss_amt;
   end

   cfg_stage_regs #(.DIV_W(DIV_W), .AMT_W(AMT_W), .DIV_DEFAULT(DIV_DEFAULT)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (stage_wr),
      .wr_addr(acc_addr),
      .wr_data(acc_wdata),
      .load   (copy_fire),
      .src_div(src_div),
      .src_up (src_up),
      .src_dn (src_dn),
      .src_amt(src_amt),
      .st_div (st_div),
      .st_up  (st_up),
      .st_dn  (st_dn),
      .st_amt (st_amt)
   );

   always_comb begin
      flag_set            = '0;
      flag_set[FLAG_CMD]  = cmd_wr && !cmd_ok;
      flag_set[FLAG_ADDR] = wr_req && (acc_addr >= ADDR_STATUS);
   end

   cfg_status_flags #(.NFLAG(NUM_FLAGS)) u_flags (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (flag_set),
      .clear(clear_fire),
      .flags(status_q)
   );

   always_comb begin
      case (acc_addr)
         ADDR_DIV_LO: rd_mux = st_div[7:0];
         ADDR_DIV_HI: rd_mux = {{PAD_W{1'b0}}, st_div[DIV_W-1:8]};
         ADDR_SPREAD: rd_mux = {st_up, st_dn, {GAP_W{1'b0}}, st_amt};
         ADDR_STATUS: rd_mux = {{(8-NUM_FLAGS){1'b0}}, status_q};
         default:     rd_mux = 8'h00;
      endcase
      if (acc_write) acc_ok = (acc_addr == ADDR_CMD) ? cmd_ok : stage_addr;
      else           acc_ok = read_addr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_ack   <= 1'b0;
         rsp_rdata <= 8'h00;
      end else begin
         rsp_valid <= acc_valid;
         rsp_ack   <= acc_valid && acc_ok;
         rsp_rdata <= (rd_req && read_addr) ? rd_mux : 8'h00;
      end
   end
endmodule

// File: rtl/cfg_shadow_bank_chk.sv
module cfg_shadow_bank_chk #(
   parameter int DIV_W = 11,
   parameter int AMT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_valid,
   input logic             acc_write,
   input logic [7:0]       acc_addr,
   input logic [7:0]       acc_wdata,
   input logic             rsp_valid,
   input logic             rsp_ack,
   input logic [7:0]       rsp_rdata,
   input logic [DIV_W-1:0] div_m,
   input logic [AMT_W-1:0] ss_amt,
   input logic             store_fire,
   input logic [1:0]       status_q
);
   localparam int HI_W = DIV_W - 8;

   AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !rsp_valid); // R2

   AST_LIVE_ONLY_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (div_m != $past(div_m) || ss_amt != $past(ss_amt)) |-> $past(store_fire)); // R3

   AST_STORE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      store_fire |=> rsp_valid && rsp_ack); // R3

   AST_BAD_CMD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && acc_addr == 8'h00 &&
       (!acc_wdata[7] || acc_wdata[3] || acc_wdata[6:4] != ~acc_wdata[2:0]))
      |=> status_q[0] && !rsp_ack); // R5

   AST_CMD_READ_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && acc_addr == 8'h00) |=> rsp_valid && !rsp_ack && rsp_rdata == 8'h00); // R6

   AST_HIGH_WRITE_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && acc_addr >= 8'h04) |=> !rsp_ack && status_q[1]); // R7

   AST_DIV_HI_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && acc_addr == 8'h02) |=> (rsp_rdata >> HI_W) == 8'h00); // R8
endmodule

bind cfg_shadow_bank cfg_shadow_bank_chk #(.DIV_W(DIV_W), .AMT_W(AMT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_write (acc_write),
   .acc_addr  (acc_addr),
   .acc_wdata (acc_wdata),
   .rsp_valid (rsp_valid),
   .rsp_ack   (rsp_ack),
   .rsp_rdata (rsp_rdata),
   .div_m     (div_m),
   .ss_amt    (ss_amt),
   .store_fire(store_fire),
   .status_q  (status_q)
);

// File: tb/tb_cfg_shadow_bank.sv
module tb_cfg_shadow_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [7:0]  acc_addr = 8'h00;
   logic [7:0]  acc_wdata = 8'h00;
   logic        rsp_valid, rsp_ack;
   logic [7:0]  rsp_rdata;
   logic [10:0] div_m;
   logic        ss_up, ss_dn;
   logic [4:0]  ss_amt;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // behavioural reference state
   int s_div = 32, s_up = 0, s_dn = 0, s_amt = 0;
   int m_div = 32, m_up = 0, m_dn = 0, m_amt = 0;
   int f_cmd = 0, f_addr = 0;

   always #10 clk = ~clk;

   cfg_shadow_bank dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
      .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .div_m(div_m), .ss_up(ss_up),
      .ss_dn(ss_dn), .ss_amt(ss_amt)
   );

   task automatic check(string tag, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   // one host cycle; called on a falling edge, returns on the next falling edge
   task automatic step(bit v, bit w, int a, int d, string tag);
      int e_ack = 0, e_rd = 0;
      int c_lo, c_hi;
      acc_valid = v; acc_write = w; acc_addr = 8'(a); acc_wdata = 8'(d);
      if (v && !w) begin
         case (a)
            1: begin e_ack = 1; e_rd = s_div % 256; end
            2: begin e_ack = 1; e_rd = s_div / 256; end
            3: begin e_ack = 1; e_rd = s_up * 128 + s_dn * 64 + s_amt; end
            4: begin e_ack = 1; e_rd = f_addr * 2 + f_cmd; end
            default: ;
         endcase
      end else if (v && w) begin
         if (a == 0) begin
            c_lo = d % 8; c_hi = (d / 16) % 8;
            if ((d / 128) % 2 == 1 && (d / 8) % 2 == 0 && c_hi == 7 - c_lo) begin
               e_ack = 1;
               if (c_lo % 2 == 1 || (c_lo / 2) % 2 == 1) begin
                  if ((c_lo / 2) % 2 == 1) begin
                     m_div = s_div; m_up = s_up; m_dn = s_dn; m_amt = s_amt;
                  end
                  if (c_lo % 2 == 1) begin
                     s_div = m_div; s_up = m_up; s_dn = m_dn; s_amt = m_amt;
                  end
               end
               if ((c_lo / 4) % 2 == 1) begin f_cmd = 0; f_addr = 0; end
            end else f_cmd = 1;
         end else if (a >= 1 && a <= 3) begin
            e_ack = 1;
            if (a == 1) s_div = (s_div / 256) * 256 + d;
            if (a == 2) s_div = (d % 8) * 256 + s_div % 256;
            if (a == 3) begin s_up = (d / 128) % 2; s_dn = (d / 64) % 2; s_amt = d % 32; end
         end else f_addr = 1;
      end
      @(negedge clk);
      check(tag, "rsp_valid", int'(rsp_valid), int'(v));
      if (v) begin
         check(tag, "rsp_ack", int'(rsp_ack), e_ack);
         check(tag, "rsp_rdata", int'(rsp_rdata), e_rd);
      end
      check(tag, "div_m", int'(div_m), m_div);
      check(tag, "ss_up", int'(ss_up), m_up);
      check(tag, "ss_dn", int'(ss_dn), m_dn);
      check(tag, "ss_amt", int'(ss_amt), m_amt);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      step(0, 0, 0, 0, "R1");
      for (int a = 1; a <= 4; a++) step(1, 0, a, 0, "R1");
      // R2 staging writes leave live outputs alone; R8 pad bits
      step(1, 1, 1, 8'h5A, "R2");
      step(1, 1, 2, 8'hFF, "R8");
      step(1, 1, 3, 8'hFF, "R8");
      step(0, 0, 0, 0, "R2");
      step(1, 0, 2, 0, "R8");
      step(1, 0, 3, 0, "R8");
      // R3 store
      step(1, 1, 0, 8'hD2, "R3");
      step(1, 0, 1, 0, "R3");
      // R4 copy restores staging from live
      step(1, 1, 1, 8'h11, "R4");
      step(1, 1, 3, 8'h03, "R4");
      step(1, 0, 1, 0, "R4");
      step(1, 1, 0, 8'hE1, "R4");
      step(1, 0, 1, 0, "R4");
      step(1, 0, 3, 0, "R4");
      // R5 malformed commands
      step(1, 1, 0, 8'hE2, "R5");
      step(1, 1, 0, 8'h61, "R5");
      step(1, 1, 0, 8'hE9, "R5");
      step(1, 0, 4, 0, "R5");
      // R6 command read
      step(1, 0, 0, 0, "R6");
      // R7 rejected addresses
      step(1, 1, 4, 8'hFF, "R7");
      step(1, 1, 7, 8'h01, "R7");
      step(1, 0, 9, 0, "R7");
      step(1, 0, 4, 0, "R7");
      // R9 clear
      step(1, 1, 0, 8'hB4, "R9");
      step(1, 0, 4, 0, "R9");
      // R10 store and copy in one command, then an empty command
      step(1, 1, 1, 8'hC4, "R10");
      step(1, 1, 2, 8'h02, "R10");
      step(1, 1, 3, 8'h4A, "R10");
      step(1, 1, 0, 8'hC3, "R10");
      step(1, 0, 1, 0, "R10");
      step(1, 0, 3, 0, "R10");
      step(1, 1, 1, 8'h33, "R10");
      step(1, 1, 0, 8'hF0, "R10");
      step(1, 0, 1, 0, "R10");
      step(1, 0, 4, 0, "R10");
      step(0, 0, 0, 0, "R10");
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule